// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block moves a processor between full-speed run and three progressively deeper power-saving modes: doze, nap and sleep. It produces one clock enable per functional unit, an enable that lets the caches keep answering coherence snoops, and an enable for the clock-generating PLL. While the processor runs, each unit that reports itself idle has its clock enable withdrawn individually.

Each deeper mode gives up one more resource. Doze stops every unit clock but keeps snooping. Nap also stops snooping but leaves the PLL running, so a wake returns to run quickly. Sleep also turns the PLL off. Waking from sleep therefore passes through a relock state whose length is a fixed number of clock cycles, derived from the clock frequency and the required relock time in microseconds. A `ready` flag shows when the processor runs at full speed.

Software requests a mode only while the block is in run. Once the block is in a low-power state, only the wake event moves it.

Top module: `pwr_mode_seq`

## Requirements
- R1: The reset (`rst_n` low, asynchronous) puts the block in run: `pwr_state` = 0, `snoop_en` = 1, `pll_en` = 1, `ready` = 1.
- R2: In run, `unit_clk_en[i]` equals the inverse of `unit_idle[i]` in the same cycle, for each unit independently.
- R3: `mode_req` codes are 0 = none, 1 = doze, 2 = nap, 3 = sleep. A non-zero request sampled at a clock edge while in run sets `pwr_state` to the target after that edge. The state codes are run 0, doze 1, nap 2, sleep 3, relock 4.
- R4: In every state other than run, all `unit_clk_en` bits are 0 and `ready` is 0. On entry to a low-power mode, every unit enable drops in the same cycle that the state changes.
- R5: `snoop_en` is 1 after an edge exactly when the state before that edge was run or doze. It therefore drops one cycle after the state enters nap or sleep.
- R6: `pll_en` is 0 after an edge exactly when the state before that edge was sleep. It therefore drops one cycle after the state enters sleep.
- R7: `wake` sampled high in doze or nap returns the state to run after that edge.
- R8: `wake` sampled high in sleep moves the state to relock. Relock lasts exactly `CLK_MHZ*RELOCK_US` cycles and then returns to run. `ready` stays 0 throughout.
- R9: `mode_req` is ignored in doze, nap, sleep and relock, and `wake` is ignored in run and relock. The state is unchanged, and a request still held when the block is back in run is then taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 2 | Requested low-power mode (0 none, 1 doze, 2 nap, 3 sleep) |
| unit_idle | input | NUM_UNITS | Per-unit idle indicators |
| wake | input | 1 | Wake event |
| unit_clk_en | output | NUM_UNITS | Per-unit clock enables |
| snoop_en | output | 1 | Cache snoop enable |
| pll_en | output | 1 | PLL enable |
| ready | output | 1 | Full-speed operation available |
| pwr_state | output | 3 | Current state code |

## Verification
The bound checker watches four things on every cycle: that the unit enables and `ready` stay low outside run, the one-cycle lag of the snoop and PLL enables behind the state, the wake transitions out of doze and nap, and the hold of every low-power state without a wake. It also counts the relock window against its fixed length. The bench scenarios show what the checker cannot. They cover the exact per-unit idle gating across several idle patterns, requests that are ignored and then taken after the return to run, and a reset that arrives in the middle of a low-power mode.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [2:0] {
    PS_RUN    = 3'd0,
    PS_DOZE   = 3'd1,
    PS_NAP    = 3'd2,
    PS_SLEEP  = 3'd3,
    PS_RELOCK = 3'd4
  } pstate_t;

  localparam logic [1:0] REQ_NONE  = 2'd0;
  localparam logic [1:0] REQ_DOZE  = 2'd1;
  localparam logic [1:0] REQ_NAP   = 2'd2;
  localparam logic [1:0] REQ_SLEEP = 2'd3;

  // Relock length in reference cycles; never below two so the timer has a range.
  function automatic int unsigned relock_cycles(int unsigned mhz, int unsigned us);
    int unsigned n;
    n = mhz * us;
    return (n < 2) ? 2 : n;
  endfunction

  function automatic pstate_t req_target(logic [1:0] r);
    case (r)
      REQ_DOZE:  return PS_DOZE;
      REQ_NAP:   return PS_NAP;
      REQ_SLEEP: return PS_SLEEP;
      default:   return PS_RUN;
    endcase
  endfunction

  function automatic logic keeps_snoop(pstate_t s);
    return (s == PS_RUN) || (s == PS_DOZE);
  endfunction

  function automatic logic keeps_pll(pstate_t s);
    return s != PS_SLEEP;
  endfunction
endpackage

// File: rtl/pms_relock_timer.sv
module pms_relock_timer #(
  parameter int unsigned LIMIT = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign done = active && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!active) cnt <= '0;
    else if (done)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pms_mode_fsm.sv
module pms_mode_fsm
  import pms_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_req,
  input  logic       wake,
  input  logic       relock_done,
  output pstate_t    state,
  output logic       enter_low
);
  pstate_t nxt;

  assign enter_low = (state == PS_RUN) && (mode_req != REQ_NONE);

  always_comb begin
    nxt = state;
    case (state)
      PS_RUN:             if (enter_low)   nxt = req_target(mode_req);
      PS_DOZE, PS_NAP:    if (wake)        nxt = PS_RUN;
      PS_SLEEP:           if (wake)        nxt = PS_RELOCK;
      PS_RELOCK:          if (relock_done) nxt = PS_RUN;
      default:                             nxt = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_RUN;
    else        state <= nxt;
  end
endmodule

// File: rtl/pms_gate_drv.sv
module pms_gate_drv
  import pms_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pstate_t              state,
  input  logic [NUM_UNITS-1:0] unit_idle,
  output logic [NUM_UNITS-1:0] unit_clk_en,
  output logic                 snoop_en,
  output logic                 pll_en,
  output logic                 ready
);
  logic running;
  assign running = (state == PS_RUN);
  assign ready   = running;

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    assign unit_clk_en[g] = running & ~unit_idle[g];
  end

  // Shared resources trail the state by one cycle so unit clocks stop first.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snoop_en <= 1'b1;
      pll_en   <= 1'b1;
    end else begin
      snoop_en <= keeps_snoop(state);
      pll_en   <= keeps_pll(state);
    end
  end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 4,
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned RELOCK_US = 100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode_req,
  input  logic [NUM_UNITS-1:0] unit_idle,
  input  logic                 wake,
  output logic [NUM_UNITS-1:0] unit_clk_en,
  output logic                 snoop_en,
  output logic                 pll_en,
  output logic                 ready,
  output logic [2:0]           pwr_state
);
  localparam int unsigned RELOCK_CYCLES = relock_cycles(CLK_MHZ, RELOCK_US);

  pstate_t state;
  logic    enter_low;
  logic    relock_done;
  logic    relock_active;

  assign relock_active = (state == PS_RELOCK);
  assign pwr_state     = state;

  pms_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_req    (mode_req),
    .wake        (wake),
    .relock_done (relock_done),
    .state       (state),
    .enter_low   (enter_low)
  );

  pms_relock_timer #(.LIMIT(RELOCK_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (relock_active),
    .done   (relock_done)
  );

  pms_gate_drv #(.NUM_UNITS(NUM_UNITS)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .unit_idle   (unit_idle),
    .unit_clk_en (unit_clk_en),
    .snoop_en    (snoop_en),
    .pll_en      (pll_en),
    .ready       (ready)
  );
endmodule

// File: rtl/pms_checker.sv
module pms_checker #(
  parameter int unsigned NUM_UNITS     = 4,
  parameter int unsigned RELOCK_CYCLES = 10000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           pwr_state,
  input logic                 wake,
  input logic                 enter_low,
  input logic                 relock_done,
  input logic [NUM_UNITS-1:0] unit_clk_en,
  input logic                 snoop_en,
  input logic                 pll_en,
  input logic                 ready
);
  logic [31:0] relock_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                relock_len <= '0;
    else if (pwr_state == 3'd4) relock_len <= relock_len + 1;
    else                       relock_len <= '0;
  end

  assert_gated_outside_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 3'd0) |-> (unit_clk_en == '0) && !ready);

  assert_entry_drops_units_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enter_low |=> (unit_clk_en == '0));

  assert_snoop_lag_nap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd2 || pwr_state == 3'd3) |=> !snoop_en);

  assert_snoop_kept_doze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd1) |=> snoop_en);

  assert_pll_off_sleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd3) |=> !pll_en);

  assert_pll_on_else_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 3'd3) |=> pll_en);

  assert_quick_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_state == 3'd1 || pwr_state == 3'd2) && wake) |=> (pwr_state == 3'd0));

  assert_relock_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd4) |-> (relock_len < RELOCK_CYCLES));

  assert_relock_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd4 && relock_len == RELOCK_CYCLES - 1) |=> (pwr_state == 3'd0));

  assert_relock_done_time_R8: assert property (@(posedge clk) disable iff (!rst_n)
    relock_done |-> (relock_len == RELOCK_CYCLES - 1));

  assert_hold_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_state == 3'd1 || pwr_state == 3'd2 || pwr_state == 3'd3) && !wake)
      |=> $stable(pwr_state));
endmodule

bind pwr_mode_seq pms_checker #(
  .NUM_UNITS     (NUM_UNITS),
  .RELOCK_CYCLES (RELOCK_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_state   (pwr_state),
  .wake        (wake),
  .enter_low   (enter_low),
  .relock_done (relock_done),
  .unit_clk_en (unit_clk_en),
  .snoop_en    (snoop_en),
  .pll_en      (pll_en),
  .ready       (ready)
);

// File: tb/tb_pwr_mode_seq.sv
module tb_pwr_mode_seq;
  localparam int NU = 4;
  localparam int MHZ = 2;
  localparam int RUS = 100;
  localparam int RC  = MHZ * RUS;  // relock length restated from R8

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_req = 2'd0;
  logic [NU-1:0] unit_idle = '0;
  logic          wake = 1'b0;
  logic [NU-1:0] unit_clk_en;
  logic          snoop_en, pll_en, ready;
  logic [2:0]    pwr_state;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pwr_mode_seq #(.NUM_UNITS(NU), .CLK_MHZ(MHZ), .RELOCK_US(RUS)) dut (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .unit_idle(unit_idle),
    .wake(wake), .unit_clk_en(unit_clk_en), .snoop_en(snoop_en),
    .pll_en(pll_en), .ready(ready), .pwr_state(pwr_state)
  );

  // {req[2], wake, idle[4], state[3], snoop, pll, ready, en[4]}
  localparam int NV = 15;
  localparam logic [16:0] VEC [NV] = '{
    {2'd0,1'b0,4'b0101,3'd0,1'b1,1'b1,1'b1,4'b1010},
    {2'd0,1'b1,4'b0000,3'd0,1'b1,1'b1,1'b1,4'b1111},
    {2'd1,1'b0,4'b0011,3'd1,1'b1,1'b1,1'b0,4'b0000},
    {2'd2,1'b0,4'b0011,3'd1,1'b1,1'b1,1'b0,4'b0000},
    {2'd0,1'b1,4'b0011,3'd0,1'b1,1'b1,1'b1,4'b1100},
    {2'd2,1'b0,4'b0000,3'd2,1'b1,1'b1,1'b0,4'b0000},
    {2'd0,1'b0,4'b0000,3'd2,1'b0,1'b1,1'b0,4'b0000},
    {2'd3,1'b0,4'b0000,3'd2,1'b0,1'b1,1'b0,4'b0000},
    {2'd0,1'b1,4'b0000,3'd0,1'b0,1'b1,1'b1,4'b1111},
    {2'd0,1'b0,4'b0000,3'd0,1'b1,1'b1,1'b1,4'b1111},
    {2'd3,1'b0,4'b0000,3'd3,1'b1,1'b1,1'b0,4'b0000},
    {2'd0,1'b0,4'b0000,3'd3,1'b0,1'b0,1'b0,4'b0000},
    {2'd1,1'b0,4'b0000,3'd3,1'b0,1'b0,1'b0,4'b0000},
    {2'd0,1'b1,4'b0000,3'd4,1'b0,1'b0,1'b0,4'b0000},
    {2'd0,1'b0,4'b0000,3'd4,1'b0,1'b1,1'b0,4'b0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog R1..: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    #12;
    chk("R1 state", 32'(pwr_state), 0);
    chk("R1 snoop", 32'(snoop_en), 1);
    chk("R1 pll",   32'(pll_en), 1);
    chk("R1 ready", 32'(ready), 1);
    @(negedge clk); rst_n = 1'b1;

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode_req  = VEC[i][16:15];
      wake      = VEC[i][14];
      unit_idle = VEC[i][13:10];
      step();
      chk("R3 R7 R9 state", 32'(pwr_state), 32'(VEC[i][9:7]));
      chk("R5 snoop",       32'(snoop_en),  32'(VEC[i][6]));
      chk("R6 pll",         32'(pll_en),    32'(VEC[i][5]));
      chk("R4 ready",       32'(ready),     32'(VEC[i][4]));
      chk("R2 R4 unit_en",  32'(unit_clk_en), 32'(VEC[i][3:0]));
    end

    // R8: relock holds for exactly RC cycles; wake and requests ignored (R9)
    @(negedge clk);
    mode_req = 2'd1; wake = 1'b1;
    for (int k = 0; k < RC - 2; k++) begin
      step();
      chk("R8 R9 relock hold", 32'(pwr_state), 4);
      chk("R8 ready low", 32'(ready), 0);
    end
    step();
    chk("R8 relock exit", 32'(pwr_state), 0);
    chk("R8 ready back", 32'(ready), 1);
    chk("R2 en after relock", 32'(unit_clk_en), 32'hF);

    // R9 / R3: request held through relock taken once back in run
    @(negedge clk); wake = 1'b0;
    step();
    chk("R3 R9 held request taken", 32'(pwr_state), 1);
    chk("R4 units off", 32'(unit_clk_en), 0);

    // R7: wake from doze
    @(negedge clk); mode_req = 2'd0; wake = 1'b1; unit_idle = 4'b1000;
    step();
    chk("R7 doze wake", 32'(pwr_state), 0);
    chk("R2 per-unit", 32'(unit_clk_en), 32'h7);

    // R1: reset in the middle of nap
    @(negedge clk); wake = 1'b0; mode_req = 2'd2;
    step();
    @(negedge clk); mode_req = 2'd0;
    step();
    chk("R5 nap snoop off", 32'(snoop_en), 0);
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R1 mid reset state", 32'(pwr_state), 0);
    chk("R1 mid reset snoop", 32'(snoop_en), 1);
    chk("R1 mid reset pll", 32'(pll_en), 1);
    @(negedge clk); rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule